// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block turns one host command for a register and DMA style SPI slave into its wire frame. A single start pulse captures the opcode, a 24-bit address, a 32-bit data word, a transfer size, the clockless-access flag and a CRC enable. The block then hands the frame out one byte at a time on a valid/ready byte stream, which a separate serial shifter consumes.

The opcode selects how long the frame is and which fields follow it. Frames run from four to eight bytes before the optional trailer. When the CRC is enabled, the trailer is a CRC7 of every earlier byte. The block computes it byte by byte as each byte is accepted, so no lookup table is needed. An opcode outside the known set produces a one-cycle error pulse and no bytes.

Top module: `cmdfrm_encoder`

## Requirements
- R1: After reset, busy_o, byte_valid_o, done_o and err_o are all 0.
- R2: A start_i pulse seen while idle with a known opcode captures every command input at that edge. In the next cycle busy_o and byte_valid_o are 1 and byte_data_o is the opcode. Later changes on the command inputs have no effect on the frame.
- R3: The known opcodes are 0xC1 DMA write, 0xC2 DMA read, 0xC3 internal write, 0xC4 internal read, 0xC5 terminate, 0xC6 repeat, 0xC7 extended DMA write, 0xC8 extended DMA read, 0xC9 single write, 0xCA single read and 0xCF reset. Each of single read, terminate, repeat and reset sends three bytes after the opcode:
  - single read sends address bits 23:16, then 15:8, then 7:0;
  - terminate and repeat send three 0x00 bytes;
  - reset sends three 0xFF bytes.
- R4: Internal read sends the opcode, then address bits 15:8, then bits 7:0, then 0x00. Internal write sends the same two address bytes followed by the four data bytes, most significant first. For both, when the clockless flag is 1, bit 7 of the first address byte is forced to 1.
- R5: DMA read and write send the opcode, the address (bits 23:16, 15:8, 7:0), then size bits 15:8 and 7:0. The extended DMA forms send the address and then size bits 23:16, 15:8 and 7:0.
- R6: Single write sends the opcode, the three address bytes from most significant down, then data bits 31:24, 23:16, 15:8 and 7:0.
- R7: With crc_en_i captured as 1, one trailer byte follows the frame:
  - the CRC uses polynomial x^7+x^3+1, starts from 0x7F and covers every earlier byte of the frame, most significant bit first;
  - the 7-bit result sits in bits 7:1 of the trailer, and bit 0 is 0.
- R8: With crc_en_i captured as 0, no trailer byte is sent, so the frame is exactly one byte shorter.
- R9: While byte_valid_o is 1 and byte_ready_i is 0, byte_data_o and byte_valid_o hold unchanged into the next cycle. A byte counts as sent only on a cycle where byte_valid_o and byte_ready_i are both 1.
- R10: busy_o and byte_valid_o fall in the cycle after the last byte is accepted. In that same cycle done_o is 1, for exactly one cycle.
- R11: A start_i pulse seen while idle with an unknown opcode makes err_o 1 for exactly the next cycle. It sends no byte and leaves busy_o at 0.
- R12: A start_i pulse while busy_o is 1 is ignored. The current frame completes with its own bytes and length, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Target address |
| data_i | input | 32 | Write data word |
| size_i | input | 24 | Transfer size for DMA forms |
| clockless_i | input | 1 | Force the clockless bit in internal accesses |
| crc_en_i | input | 1 | Append the CRC7 trailer |
| byte_ready_i | input | 1 | Consumer accepts the current byte |
| byte_valid_o | output | 1 | A frame byte is present |
| byte_data_o | output | 8 | Current frame byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last byte |
| err_o | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
The assertions assume the following about the consumer and the source:
- The consumer may hold byte_ready_i low for any number of cycles.
- The source may raise start_i at any time, including during a frame.

The stimulus exercises both freedoms:
- It drives byte_ready_i from a pseudo-random sequence in some runs and holds it high in others.
- It raises start_i in the middle of a frame.
- It scrambles the command inputs right after each start.

The assertions otherwise assume only that inputs change away from the clock edge. The bench does this by driving every input between edges.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;
    localparam int ADDR_W    = 24;
    localparam int DATA_W    = 32;
    localparam int SIZE_W    = 24;
    localparam int CRC_W     = 7;
    localparam int FRAME_MAX = 9;
    localparam int IDX_W     = $clog2(FRAME_MAX + 1);
    localparam logic [CRC_W-1:0] CRC_SEED = '1;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    localparam logic [7:0] OP_DMA_WR   = 8'hC1;
    localparam logic [7:0] OP_DMA_RD   = 8'hC2;
    localparam logic [7:0] OP_INT_WR   = 8'hC3;
    localparam logic [7:0] OP_INT_RD   = 8'hC4;
    localparam logic [7:0] OP_TERM     = 8'hC5;
    localparam logic [7:0] OP_REPEAT   = 8'hC6;
    localparam logic [7:0] OP_XDMA_WR  = 8'hC7;
    localparam logic [7:0] OP_XDMA_RD  = 8'hC8;
    localparam logic [7:0] OP_WORD_WR  = 8'hC9;
    localparam logic [7:0] OP_WORD_RD  = 8'hCA;
    localparam logic [7:0] OP_RESET    = 8'hCF;

    function automatic logic op_known(input logic [7:0] op);
        case (op)
            OP_DMA_WR, OP_DMA_RD, OP_INT_WR, OP_INT_RD, OP_TERM, OP_REPEAT,
            OP_XDMA_WR, OP_XDMA_RD, OP_WORD_WR, OP_WORD_RD, OP_RESET:
                op_known = 1'b1;
            default: op_known = 1'b0;
        endcase
    endfunction

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [CRC_W-1:0]  crc;
        logic              done;
        logic              err;
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SIZE_W-1:0] size;
        logic              clkless;
        logic              crc_en;
    } enc_state_t;
endpackage

// File: rtl/cmdfrm_layout.sv
module cmdfrm_layout
    import cmdfrm_pkg::*;
(
    input  logic [7:0]                  op_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           data_i,
    input  logic [SIZE_W-1:0]           size_i,
    input  logic                        clkless_i,
    output logic [IDX_W-1:0]            body_len_o,
    output logic [FRAME_MAX-1:0][7:0]   body_o
);
    localparam int NADDR = ADDR_W / 8;
    localparam int NDATA = DATA_W / 8;

    logic [NADDR-1:0][7:0] abytes;
    logic [NDATA-1:0][7:0] dbytes;
    logic [2:0][7:0]       sbytes;
    logic [7:0]            int_hi;

    genvar g;
    generate
        for (g = 0; g < NADDR; g++) begin : g_abyte
            assign abytes[g] = addr_i[8*g +: 8];
        end
        for (g = 0; g < NDATA; g++) begin : g_dbyte
            assign dbytes[g] = data_i[8*g +: 8];
        end
        for (g = 0; g < 3; g++) begin : g_sbyte
            assign sbytes[g] = size_i[8*g +: 8];
        end
    endgenerate

    assign int_hi = {abytes[1][7] | clkless_i, abytes[1][6:0]};

    always_comb begin
        body_o     = '0;
        body_o[0]  = op_i;
        body_len_o = IDX_W'(4);
        case (op_i)
            OP_WORD_RD: begin
                body_o[1] = abytes[2]; body_o[2] = abytes[1]; body_o[3] = abytes[0];
            end
            OP_INT_RD: begin
                body_o[1] = int_hi; body_o[2] = abytes[0]; body_o[3] = 8'h00;
            end
            OP_TERM, OP_REPEAT: begin
                body_o[1] = 8'h00; body_o[2] = 8'h00; body_o[3] = 8'h00;
            end
            OP_RESET: begin
                body_o[1] = 8'hFF; body_o[2] = 8'hFF; body_o[3] = 8'hFF;
            end
            OP_DMA_WR, OP_DMA_RD: begin
                body_o[1] = abytes[2]; body_o[2] = abytes[1]; body_o[3] = abytes[0];
                body_o[4] = sbytes[1]; body_o[5] = sbytes[0];
                body_len_o = IDX_W'(6);
            end
            OP_XDMA_WR, OP_XDMA_RD: begin
                body_o[1] = abytes[2]; body_o[2] = abytes[1]; body_o[3] = abytes[0];
                body_o[4] = sbytes[2]; body_o[5] = sbytes[1]; body_o[6] = sbytes[0];
                body_len_o = IDX_W'(7);
            end
            OP_INT_WR: begin
                body_o[1] = int_hi; body_o[2] = abytes[0];
                body_o[3] = dbytes[3]; body_o[4] = dbytes[2];
                body_o[5] = dbytes[1]; body_o[6] = dbytes[0];
                body_len_o = IDX_W'(7);
            end
            OP_WORD_WR: begin
                body_o[1] = abytes[2]; body_o[2] = abytes[1]; body_o[3] = abytes[0];
                body_o[4] = dbytes[3]; body_o[5] = dbytes[2];
                body_o[6] = dbytes[1]; body_o[7] = dbytes[0];
                body_len_o = IDX_W'(8);
            end
            default: body_len_o = IDX_W'(4);
        endcase
    end
endmodule

// File: rtl/cmdfrm_crc7.sv
module cmdfrm_crc7 #(
    parameter int                CRC_W = 7,
    parameter logic [CRC_W-1:0]  POLY  = 7'h09,
    parameter int                BYTE_W = 8
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_i;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ byte_i[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_o = c;
    end
endmodule

// File: rtl/cmdfrm_encoder.sv
module cmdfrm_encoder
    import cmdfrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              clockless_i,
    input  logic              crc_en_i,
    input  logic              byte_ready_i,
    output logic              byte_valid_o,
    output logic [7:0]        byte_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    enc_state_t state_d, state_q;

    logic [IDX_W-1:0]          body_len;
    logic [FRAME_MAX-1:0][7:0] body;
    logic [IDX_W-1:0]          frame_len;
    logic                      last_byte;
    logic                      trailer_sel;
    logic [CRC_W-1:0]          crc_next;

    cmdfrm_layout u_layout (
        .op_i       (state_q.op),
        .addr_i     (state_q.addr),
        .data_i     (state_q.data),
        .size_i     (state_q.size),
        .clkless_i  (state_q.clkless),
        .body_len_o (body_len),
        .body_o     (body)
    );

    cmdfrm_crc7 #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i  (state_q.crc),
        .byte_i (byte_data_o),
        .crc_o  (crc_next)
    );

    assign frame_len   = body_len + IDX_W'(state_q.crc_en);
    assign last_byte   = (state_q.idx == frame_len - IDX_W'(1));
    assign trailer_sel = state_q.crc_en && (state_q.idx == body_len);
    assign byte_data_o = trailer_sel ? {state_q.crc, 1'b0} : body[state_q.idx];

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        state_d.err  = 1'b0;
        if (state_q.busy) begin
            if (byte_ready_i) begin
                state_d.crc = crc_next;
                state_d.idx = state_q.idx + IDX_W'(1);
                if (last_byte) begin
                    state_d.busy = 1'b0;
                    state_d.done = 1'b1;
                end
            end
        end else if (start_i) begin
            if (op_known(opcode_i)) begin
                state_d.busy    = 1'b1;
                state_d.idx     = '0;
                state_d.crc     = CRC_SEED;
                state_d.op      = opcode_i;
                state_d.addr    = addr_i;
                state_d.data    = data_i;
                state_d.size    = size_i;
                state_d.clkless = clockless_i;
                state_d.crc_en  = crc_en_i;
            end else begin
                state_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy_o       = state_q.busy;
    assign byte_valid_o = state_q.busy;
    assign done_o       = state_q.done;
    assign err_o        = state_q.err;

    a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_data_o)));

    a_r10_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o) && $past(byte_ready_i)));

    a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !$past(busy_o) && $past(start_i)));

    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(start_i) && byte_data_o == $past(opcode_i)));

    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !byte_ready_i) |=> ($stable(state_q.op) && $stable(state_q.idx)));

    a_r3_body_len: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> (body_len >= IDX_W'(4) && body_len <= IDX_W'(FRAME_MAX - 1)));

    a_r7_trailer_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && trailer_sel) |-> (last_byte && !byte_data_o[0]));
endmodule

// File: tb/cmdfrm_encoder_tb_top.sv
`timescale 1ns/1ps
module cmdfrm_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [23:0] addr_i = '0;
    logic [31:0] data_i = '0;
    logic [23:0] size_i = '0;
    logic        clockless_i = 1'b0;
    logic        crc_en_i = 1'b1;
    logic        byte_ready_i = 1'b1;
    logic        byte_valid_o, busy_o, done_o, err_o;
    logic [7:0]  byte_data_o;

    always #2 clk = ~clk;

    cmdfrm_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .addr_i(addr_i), .data_i(data_i), .size_i(size_i),
        .clockless_i(clockless_i), .crc_en_i(crc_en_i),
        .byte_ready_i(byte_ready_i), .byte_valid_o(byte_valid_o),
        .byte_data_o(byte_data_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R2";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural frame builder.
    bit [7:0] gq[$];
    function automatic bit known(input bit [7:0] op);
        return (op >= 8'hC1 && op <= 8'hCA) || op == 8'hCF;
    endfunction

    task automatic build(input bit [7:0] op, input bit [23:0] a, input bit [31:0] d,
                         input bit [23:0] s, input bit cl, input bit ce);
        bit [7:0] c;
        gq = {};
        gq.push_back(op);
        case (op)
            8'hCA: begin gq.push_back(a[23:16]); gq.push_back(a[15:8]); gq.push_back(a[7:0]); end
            8'hC4: begin gq.push_back(a[15:8] | {cl, 7'b0}); gq.push_back(a[7:0]); gq.push_back(8'h00); end
            8'hC5, 8'hC6: begin gq.push_back(8'h00); gq.push_back(8'h00); gq.push_back(8'h00); end
            8'hCF: begin gq.push_back(8'hFF); gq.push_back(8'hFF); gq.push_back(8'hFF); end
            8'hC1, 8'hC2: begin
                gq.push_back(a[23:16]); gq.push_back(a[15:8]); gq.push_back(a[7:0]);
                gq.push_back(s[15:8]); gq.push_back(s[7:0]);
            end
            8'hC7, 8'hC8: begin
                gq.push_back(a[23:16]); gq.push_back(a[15:8]); gq.push_back(a[7:0]);
                gq.push_back(s[23:16]); gq.push_back(s[15:8]); gq.push_back(s[7:0]);
            end
            8'hC3: begin
                gq.push_back(a[15:8] | {cl, 7'b0}); gq.push_back(a[7:0]);
                for (int k = 3; k >= 0; k--) gq.push_back(d[8*k +: 8]);
            end
            8'hC9: begin
                gq.push_back(a[23:16]); gq.push_back(a[15:8]); gq.push_back(a[7:0]);
                for (int k = 3; k >= 0; k--) gq.push_back(d[8*k +: 8]);
            end
            default: gq = {};
        endcase
        if (ce && gq.size() != 0) begin
            c = 8'hFE;  // seed 0x7F held shifted left by one
            foreach (gq[j]) begin
                c = c ^ gq[j];
                for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h12) : (c << 1);
            end
            gq.push_back(c & 8'hFE);
        end
    endtask

    // Cycle reference model.
    bit [7:0] exp_q[$];
    bit exp_busy = 0, exp_done = 0, exp_err = 0, model_on = 0;
    int obs_acc = 0;
    always @(posedge clk) begin
        bit nd, ne;
        nd = 0; ne = 0;
        if (!rst_n) begin
            exp_busy = 0; exp_q = {};
        end else begin
            if (byte_valid_o && byte_ready_i) obs_acc++;
            if (exp_busy) begin
                if (byte_ready_i) begin
                    void'(exp_q.pop_front());
                    if (exp_q.size() == 0) begin exp_busy = 0; nd = 1; end
                end
            end else if (start_i) begin
                if (known(opcode_i)) begin
                    build(opcode_i, addr_i, data_i, size_i, clockless_i, crc_en_i);
                    exp_q = gq; exp_busy = 1;
                end else ne = 1;
            end
        end
        exp_done = nd; exp_err = ne;
    end

    bit       prev_hold = 0;
    bit [7:0] prev_data = 0;
    always @(negedge clk) begin
        if (model_on) begin
            chk(busy_o === exp_busy, "R2", busy_o, exp_busy);
            chk(byte_valid_o === exp_busy, "R2", byte_valid_o, exp_busy);
            if (exp_busy) chk(byte_data_o === exp_q[0], cur_tag, byte_data_o, exp_q[0]);
            chk(done_o === exp_done, "R10", done_o, exp_done);
            chk(err_o === exp_err, "R11", err_o, exp_err);
            if (prev_hold) chk(byte_valid_o && byte_data_o === prev_data, "R9", byte_data_o, prev_data);
            prev_hold = byte_valid_o && !byte_ready_i;
            prev_data = byte_data_o;
        end
    end

    bit       bp_mode = 0;
    bit [7:0] lfsr = 8'h5A;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        byte_ready_i = bp_mode ? lfsr[0] : 1'b1;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic issue(input string tag, input bit [7:0] op, input bit [23:0] a,
                         input bit [31:0] d, input bit [23:0] s, input bit cl, input bit ce);
        int elen, base;
        build(op, a, d, s, cl, ce);
        elen = gq.size();
        cur_tag = tag;
        @(negedge clk);
        base = obs_acc;
        opcode_i = op; addr_i = a; data_i = d; size_i = s; clockless_i = cl; crc_en_i = ce;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        // scramble inputs: the frame must come from the captured values (R2)
        opcode_i = 8'h3C; addr_i = ~a; data_i = ~d; size_i = ~s; clockless_i = ~cl; crc_en_i = ~ce;
        while (exp_busy) @(negedge clk);
        @(negedge clk);
        chk(obs_acc - base == elen, (elen == 0) ? "R11" : tag, obs_acc - base, elen);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !byte_valid_o && !done_o && !err_o, "R1",
            {busy_o, byte_valid_o, done_o, err_o}, 0);
        rst_n = 1;
        @(negedge clk);
        model_on = 1;

        issue("R3", 8'hCA, 24'h123456, 0, 0, 0, 1);
        issue("R3", 8'hC5, 24'hABCDEF, 32'h1, 0, 1, 1);
        issue("R3", 8'hC6, 24'h010203, 0, 0, 0, 1);
        issue("R3", 8'hCF, 24'h000000, 0, 0, 0, 1);
        issue("R4", 8'hC4, 24'h00_1A2B, 0, 0, 0, 1);
        issue("R4", 8'hC4, 24'h00_1A2B, 0, 0, 1, 1);
        issue("R4", 8'hC3, 24'h00_0024, 32'hDEADBEEF, 0, 1, 1);
        issue("R4", 8'hC3, 24'h00_8024, 32'h01020304, 0, 0, 1);
        issue("R5", 8'hC1, 24'h345678, 0, 24'h00_1234, 0, 1);
        issue("R5", 8'hC2, 24'hFEDCBA, 0, 24'hAB_CDEF, 0, 1);
        issue("R5", 8'hC7, 24'h111111, 0, 24'h12_3456, 0, 1);
        issue("R5", 8'hC8, 24'h222222, 0, 24'hFE_DCBA, 0, 1);
        issue("R6", 8'hC9, 24'h001000, 32'hCAFEF00D, 0, 0, 1);
        issue("R7", 8'hCF, 24'h0, 0, 0, 0, 1);
        issue("R8", 8'hCA, 24'h001000, 0, 0, 0, 0);
        issue("R8", 8'hC9, 24'h00ABCD, 32'h89ABCDEF, 0, 0, 0);
        issue("R8", 8'hC3, 24'h000010, 32'h55AA55AA, 0, 1, 0);
        issue("R11", 8'h00, 24'h0, 0, 0, 0, 1);
        issue("R11", 8'hC0, 24'h0, 0, 0, 0, 1);
        issue("R11", 8'hCB, 24'h0, 0, 0, 0, 1);

        bp_mode = 1;
        for (int n = 0; n < 24; n++) begin
            bit [7:0] ops[11] = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6,
                                  8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCF};
            issue("R9", ops[n % 11], {lfsr, 8'h5C, lfsr ^ 8'h33}, {4{lfsr}} ^ 32'h1234_5678,
                  {lfsr, 16'hA5C3}, n[0], n[1] | n[2]);
        end

        // R12: second start in the middle of a frame is ignored
        bp_mode = 0;
        begin
            int base, elen;
            build(8'hC9, 24'h0A0B0C, 32'h11223344, 0, 0, 1);
            elen = gq.size();
            cur_tag = "R12";
            @(negedge clk);
            base = obs_acc;
            opcode_i = 8'hC9; addr_i = 24'h0A0B0C; data_i = 32'h11223344; crc_en_i = 1; clockless_i = 0;
            start_i = 1;
            @(negedge clk);
            opcode_i = 8'hCF; start_i = 1;
            @(negedge clk);
            @(negedge clk);
            start_i = 0;
            while (exp_busy) @(negedge clk);
            repeat (3) @(negedge clk);
            chk(obs_acc - base == elen, "R12", obs_acc - base, elen);
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule